// File: doc/BRIEF.md
# Coalescing Write Buffer with Read Forwarding

This block is a small fully associative store that sits between a producer of word writes (a processor or a write-through cache) and the memory system. Each write carries a word address. The upper bits name the line and the low bits pick the word within that line. A write to a line that already holds a live entry merges into that entry. A write to any other line opens a new entry. Each entry keeps one valid bit per word, so memory only receives the words that were actually written.

Entries leave through a drain port with a ready/valid handshake. They leave strictly in the order they were opened, and one whole line (tag, word mask and data) goes out per accepted handshake. A lookup port lets reads bypass the pending writes. When the requested word is held in the buffer, the read returns it at once. Otherwise the read is reported as a miss and is served by memory. The `empty` output rises only when nothing remains buffered, so the producer can use it to tell that a flush is complete before a synchronising release.

Top module: `coalescing_wbuf`

## Requirements
- R1: A write whose line matches a live entry that is not leaving in the same cycle merges into that entry. It sets that word's mask bit and overwrites that word, and no new entry is taken.
- R2: A write to a line with no live entry opens a new entry whose mask holds only the written word.
- R3: `drain_valid` is high whenever at least one entry is live, and it presents the oldest entry. Bit i of `drain_mask` marks word i, and word i sits at `drain_data[i*WORD_BITS +: WORD_BITS]`. One entry retires per cycle with both `drain_valid` and `drain_ready` high. The next-oldest entry follows.
- R4: With all entries live, a write to an unmatched line is refused (`wr_ready` low) unless a drain completes in that cycle. A refused write changes nothing.
- R5: With all entries live and a drain completing in the same cycle, a write to a new line is accepted and the buffer stays full.
- R6: A write to the oldest entry's line, in the cycle that entry drains, does not merge into the departing entry. It opens a fresh entry at the young end.
- R7: With `rd_valid` high, `rd_hit` is high in the same cycle when a live entry holds the addressed word, and `rd_data` returns that word. The lookup reflects the contents at the start of the cycle, so a write in that same cycle is not yet visible.
- R8: A lookup of an unbuffered line, or of an unwritten word of a buffered line, reports `rd_hit` low.
- R9: After reset `empty` is high, and `full` and `drain_valid` are low. `empty` is high exactly when no entry is live, and `full` is high exactly when every entry is live.
- R10: Of a word address, the low log2(WORDS_PER_LINE) bits (5 by default) select the word, and the remaining upper bits form the line tag shown on `drain_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | WORD_BITS | Write data |
| wr_ready | output | 1 | Write accepted this cycle; low means stall |
| rd_valid | input | 1 | Lookup request |
| rd_addr | input | ADDR_W | Word address to look up |
| rd_hit | output | 1 | Addressed word is held in the buffer |
| rd_data | output | WORD_BITS | Forwarded word, meaningful when rd_hit is high |
| drain_valid | output | 1 | Oldest entry offered to memory |
| drain_ready | input | 1 | Memory accepts the offered entry |
| drain_line | output | ADDR_W-log2(WORDS_PER_LINE) | Line tag of the offered entry |
| drain_mask | output | WORDS_PER_LINE | Written-word mask of the offered entry |
| drain_data | output | WORDS_PER_LINE*WORD_BITS | Line data of the offered entry |
| empty | output | 1 | No live entry |
| full | output | 1 | All entries live |

## Verification
The critical overlap is a write that lands in the same cycle as a completed drain. The write may target the very line that is leaving, or it may target a new line while every slot is taken. Directed steps fill the buffer and then raise `drain_ready` together with such a write. The random phase uses a narrow pool of line tags with random ready, so both collisions recur many times. A bench-side ordered model of the entries judges every cycle. It checks the accept decision, the offered line and mask, the masked data, and the forwarded read. It also confirms that the line that collided later reappears alone at the young end.

// File: rtl/cwb_pkg.sv
`timescale 1ns/1ps
package cwb_pkg;
    localparam int DEF_ENTRIES        = 4;
    localparam int DEF_WORD_BITS      = 32;
    localparam int DEF_WORDS_PER_LINE = 32;
    localparam int DEF_ADDR_W         = 30;

    // index width that stays at least one bit for a single-entry build
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cwb_line_cam.sv
`timescale 1ns/1ps
module cwb_line_cam #(
    parameter int N     = 4,
    parameter int TAG_W = 25
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = valid[i] && (tags[i] == key);
    end
endmodule

// File: rtl/cwb_onehot_idx.sv
`timescale 1ns/1ps
module cwb_onehot_idx #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/coalescing_wbuf.sv
`timescale 1ns/1ps
module coalescing_wbuf
    import cwb_pkg::*;
#(
    parameter int NUM_ENTRIES    = DEF_ENTRIES,
    parameter int WORD_BITS      = DEF_WORD_BITS,
    parameter int WORDS_PER_LINE = DEF_WORDS_PER_LINE,
    parameter int ADDR_W         = DEF_ADDR_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_valid,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [WORD_BITS-1:0]                wr_data,
    output logic                                wr_ready,
    input  logic                                rd_valid,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic                                rd_hit,
    output logic [WORD_BITS-1:0]                rd_data,
    output logic                                drain_valid,
    input  logic                                drain_ready,
    output logic [ADDR_W-$clog2(WORDS_PER_LINE)-1:0] drain_line,
    output logic [WORDS_PER_LINE-1:0]           drain_mask,
    output logic [WORDS_PER_LINE*WORD_BITS-1:0] drain_data,
    output logic                                empty,
    output logic                                full
);
    localparam int WIDX_W = $clog2(WORDS_PER_LINE);
    localparam int TAG_W  = ADDR_W - WIDX_W;
    localparam int PTR_W  = idx_width(NUM_ENTRIES);
    localparam int CNT_W  = $clog2(NUM_ENTRIES + 1);

    typedef struct packed {
        logic [NUM_ENTRIES-1:0]                                valid;
        logic [NUM_ENTRIES-1:0][TAG_W-1:0]                     tag;
        logic [NUM_ENTRIES-1:0][WORDS_PER_LINE-1:0]            mask;
        logic [NUM_ENTRIES-1:0][WORDS_PER_LINE-1:0][WORD_BITS-1:0] data;
        logic [PTR_W-1:0]                                      head;
        logic [PTR_W-1:0]                                      tail;
        logic [CNT_W-1:0]                                      count;
    } wbuf_st_t;

    wbuf_st_t st_d, st_q;

    logic [TAG_W-1:0]       wr_tag, rd_tag;
    logic [WIDX_W-1:0]      wr_word, rd_word;
    logic [NUM_ENTRIES-1:0] wr_match, rd_match, hit_eff, head_oh;
    logic [PTR_W-1:0]       hit_idx, rd_idx;
    logic                   drain_fire, can_alloc, wr_take, alloc;

    assign wr_tag  = wr_addr[ADDR_W-1:WIDX_W];
    assign wr_word = wr_addr[WIDX_W-1:0];
    assign rd_tag  = rd_addr[ADDR_W-1:WIDX_W];
    assign rd_word = rd_addr[WIDX_W-1:0];

    cwb_line_cam #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_wr_cam (
        .valid(st_q.valid), .tags(st_q.tag), .key(wr_tag), .match(wr_match)
    );
    cwb_line_cam #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_rd_cam (
        .valid(st_q.valid), .tags(st_q.tag), .key(rd_tag), .match(rd_match)
    );
    cwb_onehot_idx #(.N(NUM_ENTRIES), .IW(PTR_W)) u_hit_enc (
        .vec(hit_eff), .idx(hit_idx)
    );
    cwb_onehot_idx #(.N(NUM_ENTRIES), .IW(PTR_W)) u_rd_enc (
        .vec(rd_match), .idx(rd_idx)
    );

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_ENTRIES - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d       = st_q;
        drain_fire = st_q.valid[st_q.head] && drain_ready;
        head_oh    = '0;
        head_oh[st_q.head] = 1'b1;
        // the departing entry may not absorb a write in its last cycle
        hit_eff    = wr_match & ~(drain_fire ? head_oh : '0);
        can_alloc  = (st_q.count < CNT_W'(NUM_ENTRIES)) || drain_fire;
        wr_ready   = (|hit_eff) || can_alloc;
        wr_take    = wr_valid && wr_ready;
        alloc      = wr_take && !(|hit_eff);

        if (drain_fire) begin
            st_d.valid[st_q.head] = 1'b0;
            st_d.mask[st_q.head]  = '0;
            st_d.head             = ptr_next(st_q.head);
        end

        if (wr_take) begin
            if (|hit_eff) begin
                st_d.mask[hit_idx][wr_word] = 1'b1;
                st_d.data[hit_idx][wr_word] = wr_data;
            end else begin
                st_d.valid[st_q.tail]          = 1'b1;
                st_d.tag[st_q.tail]            = wr_tag;
                st_d.mask[st_q.tail]           = '0;
                st_d.mask[st_q.tail][wr_word]  = 1'b1;
                st_d.data[st_q.tail]           = '0;
                st_d.data[st_q.tail][wr_word]  = wr_data;
                st_d.tail                      = ptr_next(st_q.tail);
            end
        end

        case ({alloc, drain_fire})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drain_valid = st_q.valid[st_q.head];
    assign drain_line  = st_q.tag[st_q.head];
    assign drain_mask  = st_q.mask[st_q.head];
    assign drain_data  = st_q.data[st_q.head];
    assign rd_hit      = rd_valid && (|rd_match) && st_q.mask[rd_idx][rd_word];
    assign rd_data     = st_q.data[rd_idx][rd_word];
    assign empty       = (st_q.count == '0);
    assign full        = (st_q.count == CNT_W'(NUM_ENTRIES));

    // R4: occupancy never exceeds the entry count
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(NUM_ENTRIES));

    // R1: merging keeps each line in at most one entry
    a_r1_one_entry_per_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_match));

    // R3: an offered entry that is not taken stays offered with the same line
    a_r3_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid && !drain_ready |=> drain_valid && $stable(drain_line));

    // R9: an accepted write into an empty buffer clears empty next cycle
    a_r9_empty_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && empty |=> !empty);

    // R6: a write to the departing line leaves a live entry behind
    a_r6_head_collision: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid && drain_ready && wr_valid && wr_ready && (wr_tag == drain_line)
        |=> drain_valid);

    // R5: swap at full keeps the buffer full
    a_r5_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        full && drain_ready && wr_valid && !(|hit_eff) |=> full);
endmodule

// File: tb/coalescing_wbuf_test.sv
`timescale 1ns/1ps
module coalescing_wbuf_test;
    localparam int N   = 4;
    localparam int WB  = 32;
    localparam int WPL = 32;
    localparam int AW  = 30;
    localparam int TW  = AW - 5;
    localparam int LW  = WPL * WB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_valid = 1'b0, drain_ready = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [WB-1:0] wr_data = '0;
    logic wr_ready, rd_hit, drain_valid, empty, full;
    logic [WB-1:0] rd_data;
    logic [TW-1:0] drain_line;
    logic [WPL-1:0] drain_mask;
    logic [LW-1:0] drain_data;

    always #2 clk = ~clk;

    coalescing_wbuf uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
        .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_line(drain_line),
        .drain_mask(drain_mask), .drain_data(drain_data), .empty(empty), .full(full)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // ordered model: index 0 is the oldest entry
    int            mcnt = 0;
    logic [TW-1:0]  mt [0:N];
    logic [WPL-1:0] mm [0:N];
    logic [LW-1:0]  md [0:N];

    task automatic chk(input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] spread(input logic [WPL-1:0] m);
        logic [LW-1:0] r = '0;
        for (int i = 0; i < WPL; i++) if (m[i]) r[i*WB +: WB] = '1;
        return r;
    endfunction

    function automatic logic [AW-1:0] wa(input int tag, input int w);
        return {TW'(tag), 5'(w)};
    endfunction

    task automatic step(input bit wv, input logic [AW-1:0] a, input logic [WB-1:0] d,
                        input bit rv, input logic [AW-1:0] ra, input bit dr);
        bit fire, ewr, ehit;
        int hit;
        logic [WB-1:0] edat;
        @(negedge clk);
        wr_valid = wv; wr_addr = a; wr_data = d;
        rd_valid = rv; rd_addr = ra; drain_ready = dr;
        #1;
        fire = (mcnt > 0) && dr;
        hit = -1;
        for (int i = 0; i < mcnt; i++)
            if (mt[i] == a[AW-1:5] && !(fire && i == 0)) hit = i;
        ewr = (hit >= 0) || (mcnt < N) || fire;
        chk("R4", "wr_ready", LW'(wr_ready), LW'(ewr));
        chk("R9", "empty", LW'(empty), LW'(mcnt == 0));
        chk("R9", "full", LW'(full), LW'(mcnt == N));
        chk("R3", "drain_valid", LW'(drain_valid), LW'(mcnt > 0));
        if (mcnt > 0) begin
            chk("R3", "drain_line", LW'(drain_line), LW'(mt[0]));
            chk("R3", "drain_mask", LW'(drain_mask), LW'(mm[0]));
            chk("R3", "drain_data", drain_data & spread(mm[0]), md[0] & spread(mm[0]));
        end
        ehit = 1'b0; edat = '0;
        for (int i = 0; i < mcnt; i++)
            if (rv && mt[i] == ra[AW-1:5] && mm[i][ra[4:0]]) begin
                ehit = 1'b1; edat = md[i][ra[4:0]*WB +: WB];
            end
        chk(ehit ? "R7" : "R8", "rd_hit", LW'(rd_hit), LW'(ehit));
        if (ehit) chk("R7", "rd_data", LW'(rd_data), LW'(edat));
        if (wv && ewr) begin
            if (hit >= 0) begin
                mm[hit][a[4:0]] = 1'b1;
                md[hit][a[4:0]*WB +: WB] = d;
            end else begin
                mt[mcnt] = a[AW-1:5];
                mm[mcnt] = '0; mm[mcnt][a[4:0]] = 1'b1;
                md[mcnt] = '0; md[mcnt][a[4:0]*WB +: WB] = d;
                mcnt++;
            end
        end
        if (fire) begin
            for (int i = 0; i < mcnt - 1; i++) begin
                mt[i] = mt[i+1]; mm[i] = mm[i+1]; md[i] = md[i+1];
            end
            mcnt--;
        end
    endtask

    task automatic idle();
        step(0, '0, '0, 0, '0, 0);
    endtask

    task automatic drain_all();
        while (mcnt > 0) step(0, '0, '0, 0, '0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        idle();
        chk("R9", "reset empty", LW'(empty), LW'(1));
        chk("R9", "reset full", LW'(full), LW'(0));
        chk("R9", "reset drain_valid", LW'(drain_valid), LW'(0));

        step(1, wa(5, 3), 32'hA0A0_0003, 0, '0, 0);
        idle();
        chk("R2", "new entry mask", LW'(drain_mask), LW'(32'h0000_0008));
        chk("R10", "line tag", LW'(drain_line), LW'(5));
        chk("R10", "word slot", LW'(drain_data[3*WB +: WB]), LW'(32'hA0A0_0003));

        step(1, wa(5, 7), 32'hB0B0_0007, 0, '0, 0);
        step(1, wa(5, 3), 32'hC0C0_0003, 0, '0, 0);
        idle();
        chk("R1", "merged mask", LW'(drain_mask), LW'(32'h0000_0088));
        chk("R1", "overwritten word", LW'(drain_data[3*WB +: WB]), LW'(32'hC0C0_0003));
        step(0, '0, '0, 0, '0, 1);
        idle();
        chk("R1", "single entry drained", LW'(empty), LW'(1));

        step(1, wa(9, 2), 32'hD0D0_0002, 0, '0, 0);
        step(0, '0, '0, 1, wa(9, 2), 0);
        chk("R7", "forward hit", LW'(rd_hit), LW'(1));
        chk("R7", "forward data", LW'(rd_data), LW'(32'hD0D0_0002));
        step(0, '0, '0, 1, wa(9, 4), 0);
        chk("R8", "unwritten word", LW'(rd_hit), LW'(0));
        step(0, '0, '0, 1, wa(8, 2), 0);
        chk("R8", "absent line", LW'(rd_hit), LW'(0));
        step(1, wa(9, 4), 32'hE0E0_0004, 1, wa(9, 4), 0);
        chk("R7", "same-cycle write hidden", LW'(rd_hit), LW'(0));
        step(0, '0, '0, 1, wa(9, 4), 0);
        chk("R7", "write visible next cycle", LW'(rd_data), LW'(32'hE0E0_0004));
        drain_all();

        for (int t = 1; t <= 4; t++) step(1, wa(t, t), 32'h1000 + t, 0, '0, 0);
        step(1, wa(6, 0), 32'h6666, 0, '0, 0);
        chk("R4", "stall when full", LW'(wr_ready), LW'(0));
        chk("R9", "full flag", LW'(full), LW'(1));
        step(0, '0, '0, 1, wa(6, 0), 0);
        chk("R4", "refused write absent", LW'(rd_hit), LW'(0));
        chk("R4", "oldest unchanged", LW'(drain_line), LW'(1));

        step(1, wa(7, 0), 32'h7777, 0, '0, 1);
        chk("R5", "accept on swap", LW'(wr_ready), LW'(1));
        idle();
        chk("R5", "still full", LW'(full), LW'(1));
        chk("R5", "next oldest", LW'(drain_line), LW'(2));

        step(1, wa(2, 5), 32'hF0F0_0005, 0, '0, 1);
        chk("R6", "head collision accepted", LW'(wr_ready), LW'(1));
        repeat (3) step(0, '0, '0, 0, '0, 1);
        idle();
        chk("R6", "fresh young entry line", LW'(drain_line), LW'(2));
        chk("R6", "fresh young entry mask", LW'(drain_mask), LW'(32'h0000_0020));
        drain_all();

        for (int k = 0; k < 4000; k++) begin
            step($urandom_range(0, 99) < 60, wa($urandom_range(0, 5), $urandom_range(0, 3)),
                 $urandom, $urandom_range(0, 1) == 1,
                 wa($urandom_range(0, 5), $urandom_range(0, 3)),
                 $urandom_range(0, 99) < 35);
        end
        drain_all();
        idle();
        chk("R9", "empty after flush", LW'(empty), LW'(1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule